// File: doc/BRIEF.md
# Load-Multiple Register List Sequencer

This block carries out multi-register loads and stack pops for a processor core. A start pulse hands it a 16-bit register list, a base address, the number of the base register, a writeback flag and a pop flag. The sequencer finds the lowest remaining set bit of the list on every beat and issues one word read for it. It then writes the returned word to that register and clears the bit. Registers are visited from 0 upward. Bit 15 stands for the program counter, so its word is loaded last and is presented as a branch target, not as a register-file write.

Only one read is in flight at any time. The request stays raised with a steady address until the memory answers, and the next address is four bytes further on. When the list is used up, the sequencer spends one closing cycle. In that cycle it may write the advanced address back to the base register, and it always pulses done. The caller must keep start low while busy is high, because any start pulse seen during that time is ignored.

Top module: `ldm_seq`

## Requirements
- R1: For each set bit i (0..14) of the list, in ascending order of i, exactly one read is issued; in the cycle its response is valid, `rf_we_o` is high with `rf_waddr_o` = i and `rf_wdata_o` = `rd_data_i`. No register write occurs in a cycle without a response, except the closing writeback.
- R2: The first read address equals the base value; every later read address is 4 more than the previous one.
- R3: If bit 15 is set, its word is read at the address after all lower registers. It is presented on `pc_data_o` with `pc_we_o` high and `rf_we_o` low, and the sequence then closes.
- R4: With writeback requested, pop low and the base register's own bit clear in a non-empty list, the closing cycle writes base value + 4 × (number of set list bits) to the base register.
- R5: With writeback low, or with the base register's bit set in the list (pop low), the closing cycle makes no register write.
- R6: With pop high, the closing cycle of a non-empty list writes base value + 4 × (number of set bits) to register 13, whatever `base_reg_i` and `wback_i` are.
- R7: An empty list raises `done_o` in the first cycle after the start, issues no read and makes no write.
- R8: While a read is outstanding and not yet answered, `rd_req_o` stays high and `rd_addr_o` stays unchanged.
- R9: A start pulse while `busy_o` is high has no effect on the running sequence.
- R10: `done_o` is a one-cycle pulse in the cycle after the last response, and `busy_o` is low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| list_i | input | 16 | Register list, bit i selects register i, bit 15 the PC |
| base_reg_i | input | 4 | Base register number |
| base_val_i | input | 32 | Base address |
| wback_i | input | 1 | Request base update (ignored when pop is high) |
| pop_i | input | 1 | Pop: base is register 13, always updated |
| busy_o | output | 1 | Sequence in progress |
| rd_req_o | output | 1 | Read request, held until answered |
| rd_addr_o | output | 32 | Read word address |
| rd_valid_i | input | 1 | Read response valid |
| rd_data_i | input | 32 | Read response data |
| rf_we_o | output | 1 | Register-file write enable |
| rf_waddr_o | output | 4 | Register-file write index |
| rf_wdata_o | output | 32 | Register-file write data |
| pc_we_o | output | 1 | Branch-target load strobe |
| pc_data_o | output | 32 | Branch-target value |
| done_o | output | 1 | Completion pulse |

## Verification
The hardest cases to reach from the ports are those where the loaded registers and the writeback rule interact. One is a list that holds the base register's own bit, where writeback must be dropped. Another is a list that ends in bit 15, where the branch target must come after every lower register and the closing write must still be correct. Random lists drawn over the whole 16-bit space are mixed with random base numbers, flags and memory latencies of zero to three cycles. Directed runs cover the PC-only list, the full list with pop, the empty list with pop and a start pulse injected in the middle of a transfer.

// File: rtl/ldm_seq.sv
module ldm_seq #(
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int NREG   = 16,
  parameter int SP_IDX = 13
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic [NREG-1:0]         list_i,
  input  logic [$clog2(NREG)-1:0] base_reg_i,
  input  logic [AW-1:0]           base_val_i,
  input  logic                    wback_i,
  input  logic                    pop_i,
  output logic                    busy_o,
  output logic                    rd_req_o,
  output logic [AW-1:0]           rd_addr_o,
  input  logic                    rd_valid_i,
  input  logic [DW-1:0]           rd_data_i,
  output logic                    rf_we_o,
  output logic [$clog2(NREG)-1:0] rf_waddr_o,
  output logic [DW-1:0]           rf_wdata_o,
  output logic                    pc_we_o,
  output logic [DW-1:0]           pc_data_o,
  output logic                    done_o
);
  localparam int RW = $clog2(NREG);
  localparam logic [RW-1:0] PC_IDX = RW'(NREG - 1);
  localparam logic [RW-1:0] SP_SEL = RW'(SP_IDX);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_END} st_t;

  st_t            st;
  logic [NREG-1:0] pend, pend_nxt;
  logic [AW-1:0]  addr;
  logic [RW-1:0]  base_q, cur;
  logic           wb_q;
  logic           accept, beat;

  always_comb begin
    cur = '0;
    for (int i = NREG - 1; i >= 0; i--)
      if (pend[i]) cur = RW'(i);
    pend_nxt = pend;
    pend_nxt[cur] = 1'b0;
  end

  assign accept = (st == S_IDLE) && start_i;
  assign beat   = (st == S_RUN) && rd_valid_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      pend   <= '0;
      addr   <= '0;
      base_q <= '0;
      wb_q   <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          pend   <= list_i;
          addr   <= base_val_i;
          base_q <= pop_i ? SP_SEL : base_reg_i;
          wb_q   <= (list_i != '0) && (pop_i || (wback_i && !list_i[base_reg_i]));
          st     <= (list_i == '0) ? S_END : S_RUN;
        end
        S_RUN: if (rd_valid_i) begin
          pend <= pend_nxt;
          addr <= addr + AW'(4);
          if (pend_nxt == '0) st <= S_END;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy_o     = (st != S_IDLE);
  assign done_o     = (st == S_END);
  assign rd_req_o   = (st == S_RUN);
  assign rd_addr_o  = addr;
  assign pc_we_o    = beat && (cur == PC_IDX);
  assign pc_data_o  = rd_data_i;
  assign rf_we_o    = (beat && (cur != PC_IDX)) || (done_o && wb_q);
  assign rf_waddr_o = done_o ? base_q : cur;
  assign rf_wdata_o = done_o ? DW'(addr) : rd_data_i;
endmodule

// File: rtl/ldm_seq_chk.sv
module ldm_seq_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy_o,
  input logic          rd_req_o,
  input logic [AW-1:0] rd_addr_o,
  input logic          rd_valid_i,
  input logic          rf_we_o,
  input logic          pc_we_o,
  input logic          done_o
);
  AST_ONE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
    !(rf_we_o && pc_we_o)); // R3

  AST_PC_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    pc_we_o |=> done_o); // R3

  AST_HOLD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o && !rd_valid_i) |=> (rd_req_o && $stable(rd_addr_o))); // R8

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o && rd_valid_i) |=> (!rd_req_o || rd_addr_o == $past(rd_addr_o) + AW'(4))); // R2

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o)); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!rd_req_o && !rf_we_o && !pc_we_o)); // R7

  AST_WRITE_ON_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we_o && !done_o) |-> rd_valid_i); // R1
endmodule

bind ldm_seq ldm_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy_o(busy_o), .rd_req_o(rd_req_o),
  .rd_addr_o(rd_addr_o), .rd_valid_i(rd_valid_i), .rf_we_o(rf_we_o),
  .pc_we_o(pc_we_o), .done_o(done_o)
);

// File: tb/ldm_seq_test.sv
module ldm_seq_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        start_i = 1'b0, wback_i = 1'b0, pop_i = 1'b0;
  logic [15:0] list_i = '0;
  logic [3:0]  base_reg_i = '0;
  logic [31:0] base_val_i = '0, rd_data_i = '0;
  logic        rd_valid_i = 1'b0;
  logic        busy_o, rd_req_o, rf_we_o, pc_we_o, done_o;
  logic [31:0] rd_addr_o, rf_wdata_o, pc_data_o;
  logic [3:0]  rf_waddr_o;

  int n_tests = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ldm_seq uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .list_i(list_i),
    .base_reg_i(base_reg_i), .base_val_i(base_val_i), .wback_i(wback_i),
    .pop_i(pop_i), .busy_o(busy_o), .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
    .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i), .rf_we_o(rf_we_o),
    .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o), .pc_we_o(pc_we_o),
    .pc_data_o(pc_data_o), .done_o(done_o)
  );

  function automatic logic [31:0] memf(input logic [31:0] a);
    return {a[15:0], ~a[15:0]} ^ 32'h5A3C_0000;
  endfunction

  function automatic int lowest(input logic [15:0] m);
    for (int i = 0; i < 16; i++) if (m[i]) return i;
    return -1;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [15:0] lst, input logic [3:0] br, input logic [31:0] base,
                        input bit wb, input bit pp, input int maxlat, input bit poke);
    logic [15:0] rem = lst;
    logic [31:0] ea = base;
    int beats = 0, cyc = 0, lat, idx;
    bit fin = 0, last_v = 0, exp_wb;
    logic [3:0] exp_reg = pp ? 4'd13 : br;
    exp_wb = (lst != 0) && (pp || (wb && !lst[br]));
    @(negedge clk);
    list_i = lst; base_reg_i = br; base_val_i = base; wback_i = wb; pop_i = pp; start_i = 1'b1;
    lat = $urandom_range(maxlat);
    while (!fin && cyc < 300) begin
      @(negedge clk);
      start_i = 1'b0; rd_valid_i = 1'b0; cyc++;
      if (poke && cyc == 2) begin
        start_i = 1'b1; list_i = ~lst; base_val_i = ~base; base_reg_i = ~br;
      end
      if (rd_req_o) begin
        if (lat == 0) begin rd_valid_i = 1'b1; rd_data_i = memf(rd_addr_o); end
        else lat--;
      end
      #1;
      if (rd_req_o) begin
        check(rd_addr_o == ea, "R2 address", rd_addr_o, ea);
        check(rem != 0, "R1 extra read", {16'h0, rem}, 32'h0);
      end
      if (rd_valid_i && rd_req_o) begin
        idx = lowest(rem);
        if (idx == 15) begin
          check(pc_we_o && !rf_we_o, "R3 pc strobe", {30'h0, pc_we_o, rf_we_o}, 32'h2);
          check(pc_data_o == memf(ea), "R3 pc data", pc_data_o, memf(ea));
        end else begin
          check(rf_we_o && !pc_we_o && rf_waddr_o == idx[3:0], "R1 write index",
                {27'h0, rf_we_o, rf_waddr_o}, {27'h1, idx[3:0]});
          check(rf_wdata_o == memf(ea), "R1 write data", rf_wdata_o, memf(ea));
        end
        if (idx >= 0) rem[idx] = 1'b0;
        ea += 4; beats++;
        lat = $urandom_range(maxlat);
      end else if (!done_o) begin
        check(!rf_we_o && !pc_we_o, "R1 no idle write", {30'h0, rf_we_o, pc_we_o}, 32'h0);
      end
      if (done_o) begin
        fin = 1;
        check(!rd_req_o, "R10 no request at done", {31'h0, rd_req_o}, 32'h0);
        check(beats == $countones(lst), "R10 beat count", beats, $countones(lst));
        if (lst == 0) check(cyc == 1, "R7 empty completes at once", cyc, 1);
        else check(last_v, "R10 done after last response", {31'h0, last_v}, 32'h1);
        if (exp_wb)
          check(rf_we_o && rf_waddr_o == exp_reg && rf_wdata_o == base + 4 * $countones(lst),
                pp ? "R6 pop update" : "R4 writeback", rf_wdata_o, base + 4 * $countones(lst));
        else
          check(!rf_we_o, lst == 0 ? "R7 no write" : "R5 suppressed", {31'h0, rf_we_o}, 32'h0);
        if (poke) check(beats == $countones(lst), "R9 start ignored", beats, $countones(lst));
      end
      last_v = rd_valid_i;
    end
    rd_valid_i = 1'b0;
    if (!fin) check(1'b0, "R10 op timeout", cyc, 300);
    @(negedge clk);
    check(!busy_o && !done_o, "R10 idle after done", {30'h0, busy_o, done_o}, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    check(1'b0, "watchdog", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(!busy_o && !rd_req_o && !done_o && !rf_we_o && !pc_we_o, "reset state",
          {27'h0, busy_o, rd_req_o, done_o, rf_we_o, pc_we_o}, 32'h0);
    rst_n = 1'b1;
    run_op(16'h0000, 4'd3, 32'h1000, 1, 0, 0, 0); // R7
    run_op(16'h0000, 4'd2, 32'h2000, 1, 1, 1, 0); // R7 pop empty
    run_op(16'h8000, 4'd1, 32'h3000, 1, 0, 2, 0); // R3 PC only
    run_op(16'hFFFF, 4'd0, 32'h4000, 0, 1, 1, 0); // R6 full pop
    run_op(16'h0036, 4'd2, 32'h5000, 1, 0, 0, 0); // R5 base in list
    run_op(16'h80A1, 4'd4, 32'h6000, 1, 0, 3, 0); // R4
    run_op(16'h00A1, 4'd4, 32'h6100, 0, 0, 1, 0); // R5 no writeback
    run_op(16'h8421, 4'd7, 32'h7000, 1, 0, 3, 1); // R9
    for (int k = 0; k < 300; k++)
      run_op(16'($urandom), 4'($urandom), {$urandom} & 32'hFFFF_FFFC,
             1'($urandom), ($urandom_range(3) == 0), 3, ($urandom_range(7) == 0));
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule